// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a purely combinational 32-bit shifter for an integer datapath. It takes a source word, a shift amount read from a register, and a two-bit operation code. It returns the shifted word together with the last bit shifted out, so that a status register can update its carry flag from it. Only the low byte of the amount register counts. The amount rules follow the register-shift forms of a load/store core: amounts of zero, exactly the word width, and beyond it each have their own carry rule.

A `set_flags` input picks between the flag-setting form and the plain form. In the plain form the result is the same, and the carry is reported as not valid. Whenever `cout_vld` is low the status register must keep its old carry. The carry source is chosen by reusing the data shifters at one less than the amount, instead of adding a separate bit multiplexer.

Top module: `barrel_shift_cy`

## Requirements
- R1: Only bits [7:0] of `amt_reg` affect any output; bits [31:8] are ignored.
- R2: With an effective amount of 0, `result` equals `src_val` and `cout_vld` is 0, for every operation.
- R3: Operation 2'b00 (logical left) by n in 1..31 gives `src_val << n` with carry `src_val[32-n]`.
- R4: Logical left by exactly 32 gives 0 with carry `src_val[0]`; by 33..255 it gives 0 with carry 0.
- R5: Operation 2'b01 (logical right) by n in 1..31 gives `src_val >> n` with carry `src_val[n-1]`.
- R6: Logical right by exactly 32 gives 0 with carry `src_val[31]`; by 33..255 it gives 0 with carry 0.
- R7: Operation 2'b10 (arithmetic right) by n in 1..31 shifts in copies of bit 31, with carry `src_val[n-1]`.
- R8: Arithmetic right by 32..255 sets every result bit and the carry equal to `src_val[31]`.
- R9: Operation 2'b11 (rotate right) uses n mod 32. When that value r is in 1..31, the word is rotated right by r and the carry is `src_val[r-1]`.
- R10: Rotate right by a nonzero amount that is a multiple of 32 (32, 64, ..., 224) returns `src_val` unchanged, with carry `src_val[31]`.
- R11: With `set_flags` = 0, `result` is as in R2-R10 (arithmetic right saturates at 31 places), and `cout_vld` is 0.
- R12: `cout_vld` is 1 exactly when `set_flags` is 1 and the effective amount is nonzero; while `cout_vld` is 0, `cout` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| set_flags | input | 1 | 1 selects the flag-setting form |
| op_sel | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| src_val | input | 32 | Word to be shifted |
| amt_reg | input | 32 | Shift amount register; low 8 bits used |
| result | output | 32 | Shifted word |
| cout | output | 1 | Last bit shifted out |
| cout_vld | output | 1 | High when `cout` should update the carry flag |

## Verification
The block has no registers, so `result`, `cout` and `cout_vld` all settle in the same cycle the inputs change: zero cycles of latency. The bench applies a new operand set just after each rising edge. It compares all three outputs at the following falling edge against a bit-by-bit behavioural model. This leaves half a period for the logic to settle, and no check depends on event ordering at a clock edge. Directed amounts cover 0, 1, 31, 32, 33, 64, 96 and 255, plus upper-byte noise, for every operation and both flag forms. After those come several thousand random operand sets.

// File: rtl/barrel_shift_cy.sv
module barrel_shift_cy #(
  parameter int DATA_W   = 32,
  parameter int AMT_BITS = 8
) (
  input  logic              set_flags,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] amt_reg,
  output logic [DATA_W-1:0] result,
  output logic              cout,
  output logic              cout_vld
);

  localparam int RW = $clog2(DATA_W);
  localparam logic [AMT_BITS-1:0] FULL = AMT_BITS'(DATA_W);

  localparam logic [1:0] OP_LSL = 2'b00;
  localparam logic [1:0] OP_LSR = 2'b01;
  localparam logic [1:0] OP_ASR = 2'b10;
  localparam logic [1:0] OP_ROR = 2'b11;

  logic [AMT_BITS-1:0] n;
  logic [RW-1:0]       rot;
  logic                zero_n, at_full, past_full, msb;

  assign n         = amt_reg[AMT_BITS-1:0];
  assign rot       = n[RW-1:0];
  assign zero_n    = (n == '0);
  assign at_full   = (n == FULL);
  assign past_full = (n > FULL);
  assign msb       = src_val[DATA_W-1];

  logic [DATA_W-1:0]   lsl_v, lsr_v, asr_v, ror_v;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   lsl_pre, lsr_pre, ror_pre;

  // data paths
  assign lsl_v = (at_full || past_full) ? '0 : src_val << n;
  assign lsr_v = (at_full || past_full) ? '0 : src_val >> n;
  assign asr_v = (at_full || past_full) ? {DATA_W{msb}}
                                        : DATA_W'($signed(src_val) >>> n);
  assign dbl   = {src_val, src_val} >> rot;
  assign ror_v = dbl[DATA_W-1:0];

  // carry taps: shifting one place less leaves the last bit out at the edge
  assign lsl_pre = src_val << (n - 1'b1);
  assign lsr_pre = src_val >> (n - 1'b1);
  assign ror_pre = src_val >> (rot - 1'b1);

  logic c_raw;

  always_comb begin
    result = src_val;
    c_raw  = 1'b0;
    if (!zero_n) begin
      unique case (op_sel)
        OP_LSL: begin
          result = lsl_v;
          c_raw  = past_full ? 1'b0 : lsl_pre[DATA_W-1];
        end
        OP_LSR: begin
          result = lsr_v;
          c_raw  = past_full ? 1'b0 : lsr_pre[0];
        end
        OP_ASR: begin
          result = asr_v;
          c_raw  = (at_full || past_full) ? msb : lsr_pre[0];
        end
        default: begin
          result = ror_v;
          c_raw  = ror_pre[0];
        end
      endcase
    end
  end

  assign cout_vld = set_flags && !zero_n;
  assign cout     = cout_vld && c_raw;

  always_comb begin
    // R2
    zero_amt_chk: assert (!zero_n || (result == src_val && !cout_vld));
    // R11
    no_flag_chk: assert (set_flags || !cout_vld);
    // R12
    quiet_carry_chk: assert (cout_vld || !cout);
    // R4
    shl_over_chk: assert (!(op_sel == OP_LSL && past_full) || (result == '0 && !cout));
    // R6
    shr_over_chk: assert (!(op_sel == OP_LSR && past_full) || (result == '0 && !cout));
    // R8
    asr_fill_chk: assert (!(op_sel == OP_ASR && (at_full || past_full)) ||
                          ((result == {DATA_W{msb}}) && (!cout_vld || cout == msb)));
    // R9
    ror_pop_chk: assert (op_sel != OP_ROR || $countones(result) == $countones(src_val));
    // R10
    ror_wrap_chk: assert (!(op_sel == OP_ROR && rot == '0) || result == src_val);
  end

endmodule

// File: tb/barrel_shift_cy_test.sv
module barrel_shift_cy_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_flags;
  logic [1:0]  op_sel;
  logic [31:0] src_val, amt_reg;
  logic [31:0] result;
  logic        cout, cout_vld;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(PERIOD/2) clk = ~clk;

  barrel_shift_cy uut (
    .set_flags(set_flags), .op_sel(op_sel), .src_val(src_val), .amt_reg(amt_reg),
    .result(result), .cout(cout), .cout_vld(cout_vld)
  );

  task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] amt,
                       input logic f, output logic [31:0] r, output logic c, output logic v);
    int k;
    int idx;
    k = int'(amt[7:0]);
    r = a; c = 1'b0; v = f && (k != 0);
    if (k == 0) return;
    case (op)
      2'b00: begin
        for (int i = 0; i < 32; i++) r[i] = (i - k >= 0) ? a[i - k] : 1'b0;
        idx = 32 - k;
        c = (idx >= 0) ? a[idx] : 1'b0;
      end
      2'b01: begin
        for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? a[i + k] : 1'b0;
        idx = k - 1;
        c = (idx < 32) ? a[idx] : 1'b0;
      end
      2'b10: begin
        for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? a[i + k] : a[31];
        idx = (k - 1 > 31) ? 31 : k - 1;
        c = a[idx];
      end
      default: begin
        idx = k % 32;
        for (int i = 0; i < 32; i++) r[i] = a[(i + idx) % 32];
        c = (idx == 0) ? a[31] : a[idx - 1];
      end
    endcase
    if (!v) c = 1'b0;
  endtask

  function automatic string req_of(logic [1:0] op, logic [31:0] amt, logic f);
    int k;
    k = int'(amt[7:0]);
    if (amt[31:8] != 0) return "R1";
    if (!f) return "R11";
    if (k == 0) return "R2";
    case (op)
      2'b00: return (k < 32) ? "R3" : "R4";
      2'b01: return (k < 32) ? "R5" : "R6";
      2'b10: return (k < 32) ? "R7" : "R8";
      default: return (k % 32 != 0) ? "R9" : "R10";
    endcase
  endfunction

  task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] amt,
                       input logic f);
    logic [31:0] er;
    logic ec, ev;
    string tag;
    @(posedge clk);
    #1;
    op_sel = op; src_val = a; amt_reg = amt; set_flags = f;
    @(negedge clk);
    model(op, a, amt, f, er, ec, ev);
    tag = req_of(op, amt, f);
    total++;
    if (result !== er) begin
      bad++;
      $display("FAIL %s result op=%0d a=%h amt=%h f=%0d: got %h exp %h",
               tag, op, a, amt, f, result, er);
    end
    if (!ev) tag = "R12";
    total++;
    if (cout !== ec || cout_vld !== ev) begin
      bad++;
      $display("FAIL %s carry op=%0d a=%h amt=%h f=%0d: got c=%0d v=%0d exp c=%0d v=%0d",
               tag, op, a, amt, f, cout, cout_vld, ec, ev);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int amts[12] = '{0, 1, 5, 31, 32, 33, 64, 96, 224, 255, 256, 'h0000_1320};
    logic [31:0] srcs[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF, 32'h0000_0000};
    op_sel = 2'b00; src_val = '0; amt_reg = '0; set_flags = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    // R2: idle inputs with zero amount
    if (result !== 32'h0 || cout !== 1'b0 || cout_vld !== 1'b0) begin
      bad++;
      $display("FAIL R2 reset state: got %h %0d %0d exp 0 0 0", result, cout, cout_vld);
    end
    rst = 1'b0;
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        for (int m = 0; m < 12; m++)
          for (int f = 0; f < 2; f++)
            apply(2'(o), srcs[s], 32'(amts[m]), f[0]);
    // R1: noise in upper bits of the amount
    apply(2'b00, 32'h1234_5678, 32'hFFFF_FF04, 1'b1);
    apply(2'b11, 32'h1234_5678, 32'hABCD_0020, 1'b1);
    for (int i = 0; i < 4000; i++)
      apply(2'($urandom), $urandom, ($urandom % 3 == 0) ? $urandom : 32'($urandom % 70),
            1'($urandom));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule